// File: doc/BRIEF.md
# EEPROM Page Write Buffer and Programming Sequencer

This block sits behind the serial command decoder of an EEPROM model. It gathers the data bytes of a write-array command into a page buffer. When chip select rises at a clean byte boundary and the write is allowed, it commits the buffered bytes to the storage array. It then holds a busy flag for a programmable interval that stands in for the self-timed programming time. At the end of that interval it emits a one-cycle request to clear the write-enable latch.

The command decoder supplies four things: a frame-open strobe carrying the start address, one strobe per received data byte, a chip-select-rise event with a flag that says whether the bit counter sat on a byte boundary, and a write-allowed qualifier. The qualifier combines the write-enable latch and the block-protection check. While the block is busy, it tells the decoder which new commands may be accepted. Only a status read gets through.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `busy_o`, `mem_we_o` and `wel_clear_o` are low.
- R2: The k-th byte of a frame (k from 0) is written to address {start_addr_i[ADDR_W-1:5], (start_addr_i[4:0] + k) mod 32}. The upper address bits never change inside a frame, with PAGE_BYTES = 32.
- R3: A frame with more than 32 bytes wraps within its page. Each page location ends up holding the last byte that landed on it, and each location is written at most once per commit.
- R4: A commit happens only when `cs_rise_i` arrives with `byte_aligned_i` = 1, `write_ok_i` = 1 and at least one byte received. If chip select rises with `byte_aligned_i` = 0, the whole page is dropped, nothing is written and busy stays low. A frame with no data bytes is also dropped.
- R5: If `write_ok_i` = 0 when chip select rises, the frame is discarded. Busy stays low, `wel_clear_o` stays low, and the block returns to idle.
- R6: Page locations that received no byte in the frame are not written and keep their old array contents.
- R7: `busy_o` rises in the cycle after the committing `cs_rise_i`. It stays high for exactly PAGE_BYTES + CYCLE_CLKS cycles: a PAGE_BYTES-cycle array flush followed by CYCLE_CLKS cycles of programming time.
- R8: `wel_clear_o` is a single-cycle pulse. It is asserted in the first cycle in which `busy_o` is low again after a commit, and never after a discarded frame.
- R9: While busy, `cmd_accept_o` is high only for a status read (`cmd_status_rd_i` = 1). Frame-open, byte and chip-select inputs have no effect during that time. When idle, `cmd_accept_o` follows `cmd_valid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Write-array frame opens; start address valid |
| start_addr_i | input | ADDR_W | Byte address of the first data byte |
| byte_valid_i | input | 1 | One complete data byte received |
| byte_data_i | input | 8 | Received data byte |
| cs_rise_i | input | 1 | Chip select has risen |
| byte_aligned_i | input | 1 | Chip select rose with no partial byte pending |
| write_ok_i | input | 1 | Write enabled and address not protected |
| cmd_valid_i | input | 1 | Decoder presents a new command |
| cmd_status_rd_i | input | 1 | Presented command is a status read |
| cmd_accept_o | output | 1 | Presented command may proceed |
| busy_o | output | 1 | Flush or programming interval in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | 8 | Array write data |
| wel_clear_o | output | 1 | One-cycle request to clear the write-enable latch |

## Verification
Frames are driven that start at page offset 0, near the top of a page (so the bytes wrap), at the last address of the array, and with 40 bytes (so earlier bytes are overwritten). These separate a correct five-bit wrap from a carry into the page bits, and a last-byte-wins result from a first-byte-wins result. Further frames close misaligned, close without permission, or carry zero bytes, to show that each reason to drop a frame acts on its own. A full frame injected during the busy interval shows that it neither reaches the array nor extends the busy time. The exact busy length and the single clear pulse tell the flush and the timer apart from an off-by-one in either.

// File: rtl/page_writer_pkg.sv
package page_writer_pkg;
  typedef enum logic [1:0] {
    PW_IDLE,
    PW_COLLECT,
    PW_FLUSH,
    PW_PROGRAM
  } pw_state_e;
endpackage

// File: rtl/pw_page_buf.sv
module pw_page_buf #(
  parameter int PAGE_BYTES = 32,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic [OFF_W-1:0] open_off_i,
  input  logic             byte_we_i,
  input  logic [7:0]       byte_i,
  input  logic [OFF_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_hit_o,
  output logic             any_o
);
  logic [OFF_W-1:0]      off_q;
  logic [7:0]            data_w [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_w;

  // write pointer: only the in-page offset advances
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        off_q <= '0;
    else if (open_i)    off_q <= open_off_i;
    else if (byte_we_i) off_q <= off_q + 1'b1;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic [7:0] d_q;
    logic       v_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_q <= '0;
        v_q <= 1'b0;
      end else if (open_i) begin
        v_q <= 1'b0;
      end else if (byte_we_i && off_q == OFF_W'(g)) begin
        d_q <= byte_i;
        v_q <= 1'b1;
      end
    end
    assign data_w[g] = d_q;
    assign mask_w[g] = v_q;
  end

  assign rd_data_o = data_w[rd_idx_i];
  assign rd_hit_o  = mask_w[rd_idx_i];
  assign any_o     = |mask_w;
endmodule

// File: rtl/pw_cycle_timer.sv
module pw_cycle_timer #(
  parameter int CYCLE_CLKS = 1250000,
  localparam int CNT_W = $clog2(CYCLE_CLKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == LAST) run_q <= 1'b0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = run_q && (cnt_q == LAST);

  p_cnt_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q <= LAST));
  p_done_ends_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !run_q);
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import page_writer_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 1250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  input  logic              cs_rise_i,
  input  logic              byte_aligned_i,
  input  logic              write_ok_i,
  input  logic              cmd_valid_i,
  input  logic              cmd_status_rd_i,
  output logic              cmd_accept_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              wel_clear_o
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST_IDX = OFF_W'(PAGE_BYTES - 1);

  pw_state_e         state_q;
  logic [BASE_W-1:0] base_q;
  logic [OFF_W-1:0]  idx_q;
  logic              wel_q;

  logic open_w, take_w, close_w, commit_w;
  logic any_w, hit_w, tmr_start_w, tmr_done_w;
  logic [7:0] rd_data_w;

  assign open_w   = (state_q == PW_IDLE) && frame_start_i;
  assign take_w   = (state_q == PW_COLLECT) && byte_valid_i;
  assign close_w  = (state_q == PW_COLLECT) && cs_rise_i;
  // a byte completing in the closing cycle still belongs to the page
  assign commit_w = close_w && byte_aligned_i && write_ok_i && (any_w || take_w);
  assign tmr_start_w = (state_q == PW_FLUSH) && (idx_q == LAST_IDX);

  pw_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .open_i     (open_w),
    .open_off_i (start_addr_i[OFF_W-1:0]),
    .byte_we_i  (take_w),
    .byte_i     (byte_data_i),
    .rd_idx_i   (idx_q),
    .rd_data_o  (rd_data_w),
    .rd_hit_o   (hit_w),
    .any_o      (any_w)
  );

  pw_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start_w),
    .done_o  (tmr_done_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PW_IDLE;
      base_q  <= '0;
      idx_q   <= '0;
      wel_q   <= 1'b0;
    end else begin
      wel_q <= 1'b0;
      unique case (state_q)
        PW_IDLE: if (frame_start_i) begin
          base_q  <= start_addr_i[ADDR_W-1:OFF_W];
          state_q <= PW_COLLECT;
        end
        PW_COLLECT: if (cs_rise_i) begin
          idx_q   <= '0;
          state_q <= commit_w ? PW_FLUSH : PW_IDLE;
        end
        PW_FLUSH: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST_IDX) state_q <= PW_PROGRAM;
        end
        PW_PROGRAM: if (tmr_done_w) begin
          wel_q   <= 1'b1;
          state_q <= PW_IDLE;
        end
        default: state_q <= PW_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q == PW_FLUSH) || (state_q == PW_PROGRAM);
  assign cmd_accept_o = cmd_valid_i && (!busy_o || cmd_status_rd_i);
  assign mem_we_o     = (state_q == PW_FLUSH) && hit_w;
  assign mem_addr_o   = {base_q, idx_q};
  assign mem_wdata_o  = rd_data_w;
  assign wel_clear_o  = wel_q;

  p_we_while_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  p_page_fixed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PW_FLUSH && $past(state_q == PW_FLUSH)) |->
      $stable(mem_addr_o[ADDR_W-1:OFF_W]));
  p_drop_misaligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_w && !byte_aligned_i) |=> !busy_o);
  p_drop_denied_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_w && !write_ok_i) |=> (!busy_o && !wel_clear_o));
  p_wel_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clear_o |=> !wel_clear_o);
  p_wel_at_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clear_o |-> (!busy_o && $past(busy_o)));
  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && frame_start_i) |=> (state_q != PW_COLLECT));
endmodule

// File: tb/eeprom_page_writer_test.sv
`timescale 1ns/1ps
module eeprom_page_writer_test;
  localparam int AW   = 10;
  localparam int PG   = 32;
  localparam int CYC  = 40;
  localparam int MEMN = 1 << AW;
  localparam int NV   = 8;

  localparam int V_ADDR [NV] = '{'h000, 'h13C, 'h245, 'h080, 'h0A0, 'h3FF, 'h060, 'h300};
  localparam int V_N    [NV] = '{4, 8, 40, 3, 5, 1, 0, 32};
  localparam int V_SEED [NV] = '{16, 64, 128, 32, 48, 200, 7, 90};
  localparam int V_BND  [NV] = '{1, 1, 1, 0, 1, 1, 1, 1};
  localparam int V_OK   [NV] = '{1, 1, 1, 1, 0, 1, 1, 1};
  localparam string V_REQ [NV] = '{"R2", "R2", "R3", "R4", "R5", "R6", "R4", "R2"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, byte_valid = 1'b0, cs_rise = 1'b0;
  logic byte_aligned = 1'b0, write_ok = 1'b0;
  logic cmd_valid = 1'b0, cmd_status_rd = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0] byte_data = '0;
  logic cmd_accept, busy, mem_we, wel_clear;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;

  int checks = 0, fails = 0;
  int busy_cnt = 0, wel_cnt = 0;
  logic [7:0] cap [MEMN];
  logic [7:0] ref_mem [MEMN];

  always #2 clk = ~clk;

  eeprom_page_writer #(.ADDR_W(AW), .PAGE_BYTES(PG), .CYCLE_CLKS(CYC)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .frame_start_i(frame_start), .start_addr_i(start_addr),
    .byte_valid_i(byte_valid), .byte_data_i(byte_data),
    .cs_rise_i(cs_rise), .byte_aligned_i(byte_aligned), .write_ok_i(write_ok),
    .cmd_valid_i(cmd_valid), .cmd_status_rd_i(cmd_status_rd),
    .cmd_accept_o(cmd_accept), .busy_o(busy),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .wel_clear_o(wel_clear)
  );

  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (wel_clear) wel_cnt++;
    if (mem_we) cap[mem_addr] = mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad = -1;
    for (int i = 0; i < MEMN; i++)
      if (bad < 0 && cap[i] !== ref_mem[i]) bad = i;
    if (bad >= 0) chk(1'b0, req, int'(cap[bad]), int'(ref_mem[bad]));
    else          chk(1'b1, req, 0, 0);
  endtask

  task automatic run_frame(input int addr, input int n, input int seed,
                           input bit bnd, input bit ok);
    @(negedge clk);
    frame_start = 1'b1; start_addr = AW'(addr);
    @(negedge clk);
    frame_start = 1'b0;
    for (int k = 0; k < n; k++) begin
      byte_valid = 1'b1; byte_data = 8'(seed + 3 * k);
      @(negedge clk);
    end
    byte_valid = 1'b0;
    cs_rise = 1'b1; byte_aligned = bnd; write_ok = ok;
    @(negedge clk);
    cs_rise = 1'b0; byte_aligned = 1'b0; write_ok = 1'b0;
  endtask

  task automatic model(input int addr, input int n, input int seed);
    for (int k = 0; k < n; k++)
      ref_mem[(addr & ~(PG - 1)) | ((addr + k) % PG)] = 8'(seed + 3 * k);
  endtask

  task automatic clr_counts();
    @(posedge clk); #1;
    busy_cnt = 0; wel_cnt = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMN; i++) begin
      cap[i] = 8'(i) ^ 8'hA5;
      ref_mem[i] = 8'(i) ^ 8'hA5;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(mem_we == 1'b0, "R1 we", int'(mem_we), 0);
    chk(wel_clear == 1'b0, "R1 wel", int'(wel_clear), 0);
    cmd_valid = 1'b1; #1;
    chk(cmd_accept == 1'b1, "R9 idle accept", int'(cmd_accept), 1);
    cmd_valid = 1'b0;

    for (int v = 0; v < NV; v++) begin
      bit commit;
      commit = V_BND[v] != 0 && V_OK[v] != 0 && V_N[v] > 0;
      clr_counts();
      run_frame(V_ADDR[v], V_N[v], V_SEED[v], V_BND[v] != 0, V_OK[v] != 0);
      if (commit) model(V_ADDR[v], V_N[v], V_SEED[v]);
      repeat (PG + CYC + 10) @(negedge clk);
      cmp_mem(V_REQ[v]);
      chk(busy_cnt == (commit ? PG + CYC : 0), commit ? "R7 busy length" : "R4/R5 no busy",
          busy_cnt, commit ? PG + CYC : 0);
      chk(wel_cnt == (commit ? 1 : 0), "R8 wel pulse", wel_cnt, commit ? 1 : 0);
    end

    // R9: gating and ignored frame while busy
    clr_counts();
    run_frame('h1E0, 2, 11, 1'b1, 1'b1);
    model('h1E0, 2, 11);
    repeat (5) @(negedge clk);
    chk(busy == 1'b1, "R7 busy during cycle", int'(busy), 1);
    cmd_valid = 1'b1; cmd_status_rd = 1'b0; #1;
    chk(cmd_accept == 1'b0, "R9 reject while busy", int'(cmd_accept), 0);
    cmd_status_rd = 1'b1; #1;
    chk(cmd_accept == 1'b1, "R9 status read while busy", int'(cmd_accept), 1);
    cmd_valid = 1'b0; cmd_status_rd = 1'b0;
    run_frame('h1C0, 3, 77, 1'b1, 1'b1);
    repeat (PG + CYC + 10) @(negedge clk);
    chk(busy_cnt == PG + CYC, "R9 busy not extended", busy_cnt, PG + CYC);
    chk(wel_cnt == 1, "R9 single clear", wel_cnt, 1);
    cmp_mem("R9 frame ignored");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule